// File: doc/BRIEF.md
# Bus Access Trap Mailbox

This block connects a stalled guest bus to a host processor. When the guest starts a memory or I/O access, the block captures the access in a status register and keeps the guest waiting. The captured fields are the direction, the width (byte or 16-bit), the address space, a DMA flag and the address. The host polls the status register, works out what the guest wanted, and then finishes the access with one access to a data register.

For a guest write, the host reads the data register and gets the write data. For a guest read, the host writes the data register and supplies the read data. That single data-register access moves the data and also releases the guest. The release shows on the guest side as a one-cycle ready pulse. A returned read value is presented with that pulse.

The host interface has two registers. The status register sits at byte offset 0 and the data register sits at byte offset 4. Host reads return their data one cycle after the request. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `bus_trap_mailbox`

## Requirements
- R1: After reset nothing is pending, `g_ready` is low and a host read of the status register returns zero.
- R2: When `g_req` is high and the block is idle, the access is captured at the next clock edge. From then on the status register reads with bit 31 = pending, bit 30 = 16-bit access (0 = byte), bit 29 = write, bit 28 = memory space (0 = I/O) and bit 27 = DMA.
- R3: The status register holds the address in bits 19:0 for a memory access. For an I/O access it holds the address in bits 15:0 and reads bits 19:16 as zero.
- R4: Status bits 26:20 always read as zero. This includes bits 25 and 26.
- R5: While an access is pending, `g_ready` stays low and a further `g_req` is not captured. The captured fields do not change.
- R6: With a write pending, a host read at offset 4 returns the write data in bits 15:0. A byte write returns only bits 7:0, and all higher bits read zero. The read clears pending at the same clock edge, and `g_ready` is high for exactly the next cycle.
- R7: With a read pending, a host write at offset 4 clears pending at that clock edge. During the following one-cycle `g_ready` pulse, `g_rdata` carries the written `h_wdata[15:0]`. For a byte read `g_rdata` carries `h_wdata[7:0]` with the upper byte zero.
- R8: A data-register access in the wrong direction does not release the guest, and pending stays set. This means a host write while a write is pending, or a host read while a read is pending. Such a read returns zero.
- R9: With nothing pending, a host read at offset 4 returns zero and a host write at offset 4 has no effect.
- R10: The earliest a new access can be captured is the cycle after the `g_ready` pulse. A `g_req` held high during the pulse is captured one edge later.
- R11: A host access to any offset other than 0 or 4 reads zero and does not change pending or the captured access.
- R12: Host read data appears on `h_rdata` in the cycle after `h_sel` is sampled high with `h_wr` low. It holds until the next host read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g_req | input | 1 | Guest access request, held until `g_ready` |
| g_is_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| g_is_write | input | 1 | 1 = guest write, 0 = guest read |
| g_is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| g_is_dma | input | 1 | DMA flag, captured into the status register |
| g_addr | input | 20 | Guest address |
| g_wdata | input | 16 | Guest write data |
| g_ready | output | 1 | One-cycle release pulse to the guest |
| g_rdata | output | 16 | Read data returned to the guest, valid with `g_ready` |
| h_sel | input | 1 | Host register access strobe |
| h_wr | input | 1 | 1 = host write, 0 = host read |
| h_addr | input | 3 | Host byte offset (0 = status, 4 = data) |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the request |

## Verification
The bench targets these corner cases:
- **Release timing.** Ready must pulse in the cycle right after the releasing host access. A design that keeps ready high, or releases late, would let a still-asserted request be captured inside the ready cycle, or would delay the guest.
- **Wrong-direction and stray-offset accesses.** These are made while an access is pending. A design that released on any data-register access would drop pending early or return stale write data.
- **Byte accesses.** Byte writes and byte reads with non-zero upper data are run. A design without masking would leak the upper byte into the host data or into `g_rdata`.
- **I/O captures.** These use addresses with bits 19:16 set. A wrong address mask would show up in the status word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned GA_W   = 20;
  localparam int unsigned IO_AW  = 16;
  localparam int unsigned GD_W   = 16;
  localparam int unsigned HR_W   = 32;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned POS_PEND = 31;
  localparam int unsigned POS_WORD = 30;
  localparam int unsigned POS_WR   = 29;
  localparam int unsigned POS_MEM  = 28;
  localparam int unsigned POS_DMA  = 27;

  typedef struct packed {
    logic            word;
    logic            write;
    logic            mem;
    logic            dma;
    logic [GA_W-1:0] addr;
  } trap_acc_t;

  function automatic logic [HR_W-1:0] status_word(input logic pend, input trap_acc_t a);
    logic [HR_W-1:0] s;
    s = '0;
    s[POS_PEND]   = pend;
    s[POS_WORD]   = pend & a.word;
    s[POS_WR]     = pend & a.write;
    s[POS_MEM]    = pend & a.mem;
    s[POS_DMA]    = pend & a.dma;
    s[GA_W-1:0]   = pend ? a.addr : '0;
    return s;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture
  import mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            g_req,
  input  trap_acc_t       g_acc,
  input  logic [GD_W-1:0] g_wdata,
  input  logic            rel_i,
  input  logic [GD_W-1:0] rel_data_i,
  output logic            pend_o,
  output trap_acc_t       acc_o,
  output logic [GD_W-1:0] wdata_o,
  output logic            ready_o,
  output logic [GD_W-1:0] rdata_o
);
  localparam int unsigned HI_W = GD_W - BYTE_W;

  logic            pend_q, pend_d;
  logic            done_q, done_d;
  trap_acc_t       acc_q, acc_d;
  logic [GD_W-1:0] wdat_q, wdat_d;
  logic [GD_W-1:0] rdat_q, rdat_d;
  logic            take;
  logic            acc_en, rdat_en;

  assign take    = g_req && !pend_q && !done_q;
  assign acc_en  = take;
  assign rdat_en = rel_i && !acc_q.write;

  always_comb begin
    pend_d = pend_q;
    done_d = rel_i;
    if (rel_i)     pend_d = 1'b0;
    else if (take) pend_d = 1'b1;
  end

  always_comb begin
    acc_d       = g_acc;
    acc_d.addr  = g_acc.mem ? g_acc.addr
                            : {{(GA_W-IO_AW){1'b0}}, g_acc.addr[IO_AW-1:0]};
    wdat_d      = g_acc.word ? g_wdata : {{HI_W{1'b0}}, g_wdata[BYTE_W-1:0]};
    rdat_d      = acc_q.word ? rel_data_i : {{HI_W{1'b0}}, rel_data_i[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      if (acc_en) begin
        acc_q  <= acc_d;
        wdat_q <= wdat_d;
      end
      if (rdat_en) rdat_q <= rdat_d;
    end
  end

  assign pend_o  = pend_q;
  assign acc_o   = acc_q;
  assign wdata_o = wdat_q;
  assign ready_o = done_q;
  assign rdata_o = rdat_q;

  // R5
  ready_low_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !ready_o);
  // R5
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rel_i) |=> (pend_q && $stable(acc_q) && $stable(wdat_q)));
  // R6
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_i |=> (!pend_q && ready_o));
  // R10
  no_take_in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> (!pend_q && !ready_o));
  // R6
  release_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_i |-> pend_q);
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int unsigned HOST_AW = 3,
  parameter int unsigned DATA_OFS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [GD_W-1:0]    h_wdata,
  input  logic               pend_i,
  input  trap_acc_t          acc_i,
  input  logic [GD_W-1:0]    wdata_i,
  output logic               rel_o,
  output logic [GD_W-1:0]    rel_data_o,
  output logic [HR_W-1:0]    h_rdata
);
  localparam logic [HOST_AW-1:0] OFS_STAT = '0;
  localparam logic [HOST_AW-1:0] OFS_DATA = HOST_AW'(DATA_OFS);

  logic              hit_stat, hit_data, rd_en;
  logic [HR_W-1:0]   rdat_q, rdat_d;

  assign hit_stat = (h_addr == OFS_STAT);
  assign hit_data = (h_addr == OFS_DATA);
  assign rd_en    = h_sel && !h_wr;

  assign rel_o      = h_sel && hit_data && pend_i && (h_wr ? !acc_i.write : acc_i.write);
  assign rel_data_o = h_wdata;

  always_comb begin
    rdat_d = '0;
    if (hit_stat)                          rdat_d = status_word(pend_i, acc_i);
    else if (hit_data && pend_i && acc_i.write) rdat_d = {{(HR_W-GD_W){1'b0}}, wdata_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdat_q <= '0;
    else if (rd_en) rdat_q <= rdat_d;
  end

  assign h_rdata = rdat_q;

  // R4
  zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rdata[26:20] == 7'd0);
  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_data && !pend_i) |=> (h_rdata == '0));
  // R8
  wrong_dir_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_data && pend_i && !acc_i.write) |=> (h_rdata == '0));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(h_rdata));
endmodule

// File: rtl/bus_trap_mailbox.sv
module bus_trap_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned HOST_AW  = 3,
  parameter int unsigned DATA_OFS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               g_req,
  input  logic               g_is_word,
  input  logic               g_is_write,
  input  logic               g_is_mem,
  input  logic               g_is_dma,
  input  logic [GA_W-1:0]    g_addr,
  input  logic [GD_W-1:0]    g_wdata,
  output logic               g_ready,
  output logic [GD_W-1:0]    g_rdata,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [GD_W-1:0]    h_wdata,
  output logic [HR_W-1:0]    h_rdata
);
  logic            srst_n;
  trap_acc_t       g_acc, acc;
  logic            pend, rel;
  logic [GD_W-1:0] rel_data, wdat;

  assign g_acc = '{word: g_is_word, write: g_is_write, mem: g_is_mem,
                   dma: g_is_dma, addr: g_addr};

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mbx_capture u_cap (
    .clk(clk), .rst_n(srst_n), .g_req(g_req), .g_acc(g_acc), .g_wdata(g_wdata),
    .rel_i(rel), .rel_data_i(rel_data), .pend_o(pend), .acc_o(acc),
    .wdata_o(wdat), .ready_o(g_ready), .rdata_o(g_rdata)
  );

  mbx_host_if #(.HOST_AW(HOST_AW), .DATA_OFS(DATA_OFS)) u_host (
    .clk(clk), .rst_n(srst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .pend_i(pend), .acc_i(acc), .wdata_i(wdat),
    .rel_o(rel), .rel_data_o(rel_data), .h_rdata(h_rdata)
  );
endmodule

// File: tb/tb_bus_trap_mailbox.sv
module tb_bus_trap_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        g_req = 1'b0, g_is_word = 1'b0, g_is_write = 1'b0, g_is_mem = 1'b0, g_is_dma = 1'b0;
  logic [19:0] g_addr = '0;
  logic [15:0] g_wdata = '0;
  logic        g_ready;
  logic [15:0] g_rdata;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [2:0]  h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [31:0] h_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_trap_mailbox dut (
    .clk(clk), .rst_n(rst_n), .g_req(g_req), .g_is_word(g_is_word),
    .g_is_write(g_is_write), .g_is_mem(g_is_mem), .g_is_dma(g_is_dma),
    .g_addr(g_addr), .g_wdata(g_wdata), .g_ready(g_ready), .g_rdata(g_rdata),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata)
  );

  function automatic logic [31:0] exp_stat(logic w, logic wr, logic m, logic d, logic [19:0] a);
    logic [31:0] s;
    s = '0;
    s[31] = 1'b1; s[30] = w; s[29] = wr; s[28] = m; s[27] = d;
    s[19:0] = m ? a : {4'h0, a[15:0]};
    return s;
  endfunction

  function automatic logic [15:0] mask_b(logic w, logic [15:0] v);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
    @(negedge clk); h_sel = 1'b0; d = h_rdata;
  endtask

  task automatic host_wr(logic [2:0] a, logic [15:0] v);
    @(negedge clk); h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = v;
    @(negedge clk); h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic guest_go(logic w, logic wr, logic m, logic d, logic [19:0] a, logic [15:0] wd);
    @(negedge clk);
    g_req = 1'b1; g_is_word = w; g_is_write = wr; g_is_mem = m; g_is_dma = d;
    g_addr = a; g_wdata = wd;
  endtask

  // one full transaction with checks; wrong-direction and stray probes optional
  task automatic transact(logic w, logic wr, logic m, logic d, logic [19:0] a,
                          logic [15:0] wd, logic [15:0] hd, bit probe);
    logic [31:0] r;
    logic [31:0] st;
    st = exp_stat(w, wr, m, d, a);
    guest_go(w, wr, m, d, a, wd);
    host_rd(3'd0, r);
    chk("R2/R3/R4 status", r, st);
    chk("R5 ready low while pending", {31'd0, g_ready}, 32'd0);
    if (probe) begin
      g_addr = ~a; g_is_word = ~w;
      host_rd(3'd2, r);
      chk("R11 stray offset reads zero", r, 32'd0);
      host_wr(3'd0, 16'hFFFF);
      if (wr) host_wr(3'd4, 16'h1234);
      else begin
        host_rd(3'd4, r);
        chk("R8 wrong-direction read zero", r, 32'd0);
      end
      chk("R8 no release", {31'd0, g_ready}, 32'd0);
      host_rd(3'd0, r);
      chk("R5/R8/R11 still pending, fields held", r, st);
    end
    if (wr) begin
      host_rd(3'd4, r);
      chk("R6 write data to host", r, {16'd0, mask_b(w, wd)});
      chk("R6 ready pulse", {31'd0, g_ready}, 32'd1);
    end else begin
      host_wr(3'd4, hd);
      chk("R7 ready pulse", {31'd0, g_ready}, 32'd1);
      chk("R7 read data to guest", {16'd0, g_rdata}, {16'd0, mask_b(w, hd)});
    end
    g_req = 1'b0;
    @(negedge clk);
    chk("R6 ready one cycle", {31'd0, g_ready}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 ready after reset", {31'd0, g_ready}, 32'd0);
    host_rd(3'd0, r);
    chk("R1 status after reset", r, 32'd0);

    // R9: idle data access
    host_wr(3'd4, 16'hBEEF);
    host_rd(3'd4, r);
    chk("R9 idle data read zero", r, 32'd0);
    host_rd(3'd0, r);
    chk("R9 idle write no effect", r, 32'd0);

    // directed corners
    transact(1'b0, 1'b1, 1'b0, 1'b1, 20'hF1234, 16'hA55A, 16'h0, 1'b1); // byte I/O write, R3 mask
    transact(1'b1, 1'b1, 1'b1, 1'b0, 20'hABCDE, 16'hC3D2, 16'h0, 1'b1); // word mem write
    transact(1'b0, 1'b0, 1'b1, 1'b0, 20'h80001, 16'h0, 16'h9F7E, 1'b1); // byte mem read
    transact(1'b1, 1'b0, 1'b0, 1'b1, 20'h5FFFF, 16'h0, 16'h6E21, 1'b1); // word I/O read

    // R10: request held through the ready pulse
    guest_go(1'b1, 1'b0, 1'b0, 1'b0, 20'h00042, 16'h0);
    host_wr(3'd4, 16'h7777);
    chk("R10 ready pulse", {31'd0, g_ready}, 32'd1);
    host_rd(3'd0, r);
    chk("R10 no capture in ready cycle", r, 32'd0);
    host_rd(3'd0, r);
    chk("R10 capture after ready", r, exp_stat(1'b1, 1'b0, 1'b0, 1'b0, 20'h00042));
    host_wr(3'd4, 16'h1111);
    g_req = 1'b0;
    @(negedge clk);

    // R12: host read data holds
    host_rd(3'd0, r);
    repeat (3) @(negedge clk);
    chk("R12 read data holds", h_rdata, r);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [19:0] a;
      logic [15:0] wd, hd;
      logic [3:0]  f;
      f  = 4'($urandom);
      a  = 20'($urandom);
      wd = 16'($urandom);
      hd = 16'($urandom);
      transact(f[0], f[1], f[2], f[3], a, wd, hd, ($urandom % 4) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule